// File: doc/BRIEF.md
# XOR Tree Board Test Controller

This block selects the board-test personality of a chip's pin ring. During reset it looks at four test strap inputs and a bus-alive input, and picks one of three modes: functional operation, a float mode in which every driver and every internal pull resistor is switched off, or a parity-tree mode used at board test to prove that every peripheral pin is soldered and connected.

In parity-tree mode the received values of the peripheral pins are folded into two independent XOR chains. Chain A covers the host-bus group and drives its result on the pin that is normally the local-bus read strobe. Chain B covers the indicator, side-band and local-bus data/address group and drives its result on the pin that is normally the local-bus write strobe. Every other output enable is forced off, so a tester drives the pins and watches the two strobes. Chain membership is set by two bit-mask parameters over the pin vector. The bus-alive input must stay high for the whole test; if it falls, the block returns to functional operation and stays there until the next reset.

Top module: `xortest_ctrl`

## Requirements
- R1: When the straps at reset match neither test pattern, pad output enables and pull enables equal the functional ones, and both strobe pins carry their functional value and enable.
- R2: Straps (test=1, execute=0, test clock=0, test data=1) at reset select float mode: every pad output enable, every pull enable and both strobe enables are 0.
- R3: Straps (test=1, execute=1, test clock=0, test data=1) with bus-alive=1 at reset select parity-tree mode: every pad output enable is 0, both strobe enables are 1, pull enables equal the functional ones.
- R4: The parity-tree strap pattern with bus-alive=0 at reset selects functional operation.
- R5: In parity-tree mode the read-strobe value equals the XOR of the pin inputs whose bit is set in the chain A mask, in the same cycle as the inputs.
- R6: In parity-tree mode the write-strobe value equals the XOR of the pin inputs whose bit is set in the chain B mask, in the same cycle.
- R7: With the default masks (chain A bits 0 to 20, chain B bits 21 to 46, bit 47 in neither), toggling one pin toggles exactly the strobe of its chain, and toggling bit 47 toggles neither.
- R8: A low bus-alive in parity-tree mode returns the block to functional operation from the next clock edge, and a later high bus-alive does not re-enter the test mode.
- R9: Strap changes after reset has been released have no effect on the mode.
- R10: A test clock strap of 1, or a test strap of 0, at reset selects functional operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_test | input | 1 | Test-enable strap |
| strap_exec | input | 1 | Execute strap (0 float, 1 parity tree) |
| strap_tck | input | 1 | Test clock strap, must be 0 for a test mode |
| strap_tdi | input | 1 | Test data strap, must be 1 for a test mode |
| bus_alive | input | 1 | High while the host bus is powered; required for parity-tree mode |
| pin_in | input | NPINS | Input-buffer values of the peripheral pins |
| func_oe | input | NPINS | Functional output enables |
| func_pull | input | NPINS | Functional pull-resistor enables |
| rd_func_val | input | 1 | Functional read-strobe value |
| rd_func_oe | input | 1 | Functional read-strobe enable |
| wr_func_val | input | 1 | Functional write-strobe value |
| wr_func_oe | input | 1 | Functional write-strobe enable |
| pad_oe | output | NPINS | Pad output enables |
| pad_pull | output | NPINS | Pad pull-resistor enables |
| rd_pad_val | output | 1 | Read-strobe pin value (chain A result in test) |
| rd_pad_oe | output | 1 | Read-strobe pin enable |
| wr_pad_val | output | 1 | Write-strobe pin value (chain B result in test) |
| wr_pad_oe | output | 1 | Write-strobe pin enable |

## Verification
A wrongly latched mode shows at once after reset as enables that do not match the selected personality: functional enables leaking in float mode, or strobes undriven in parity-tree mode. A mode register that fails to drop on a bus-alive fall, or that re-enters test later, shows one edge after the input change as strobes still carrying parity instead of functional values. A wrong chain mask shows in the same cycle as the input change, when a single-pin toggle flips the wrong strobe, both, or neither.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC  = 2'd0,
        MODE_FLOAT = 2'd1,
        MODE_XOR   = 2'd2
    } tmode_e;

    typedef struct packed {
        logic test_en;
        logic exec;
        logic tck;
        logic tdi;
    } strap_t;

    typedef struct packed {
        logic val;
        logic oe;
    } drv_t;

    localparam int NUM_CHAINS = 2;

    function automatic tmode_e decode_straps(strap_t s, logic alive);
        tmode_e m;
        m = MODE_FUNC;
        if (s.test_en && !s.tck && s.tdi) begin
            if (!s.exec)
                m = MODE_FLOAT;
            else if (alive)
                m = MODE_XOR;
        end
        return m;
    endfunction

endpackage

// File: rtl/xtc_strap_latch.sv
module xtc_strap_latch
    import xtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t straps,
    input  logic   alive,
    output tmode_e mode
);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= decode_straps(straps, alive);
        else if (mode == MODE_XOR && !alive)
            mode <= MODE_FUNC;
    end

    // R8: losing bus power leaves the test mode on the next edge
    assert_isolate_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_XOR && !alive) |=> (mode == MODE_FUNC));

    // R9: outside reset the mode only holds or drops from parity tree to functional
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ($stable(mode) ||
                         ($past(mode) == MODE_XOR && mode == MODE_FUNC)));

endmodule

// File: rtl/xtc_xor_chain.sv
module xtc_xor_chain #(
    parameter int              NPINS = 48,
    parameter logic [NPINS-1:0] MASK = '1
) (
    input  logic [NPINS-1:0] pins,
    output logic             parity
);

    logic [NPINS-1:0] members;
    logic [NPINS:0]   fold;

    assign members = pins & MASK;
    assign fold[0] = 1'b0;

    for (genvar i = 0; i < NPINS; i++) begin : g_fold
        assign fold[i+1] = fold[i] ^ members[i];
    end

    assign parity = fold[NPINS];

endmodule

// File: rtl/xtc_pad_gate.sv
module xtc_pad_gate
    import xtc_pkg::*;
#(
    parameter int NPINS = 48
) (
    input  tmode_e                   mode,
    input  logic [NPINS-1:0]         func_oe,
    input  logic [NPINS-1:0]         func_pull,
    input  drv_t                     rd_func,
    input  drv_t                     wr_func,
    input  logic [NUM_CHAINS-1:0]    chain_par,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_pull,
    output drv_t                     rd_pad,
    output drv_t                     wr_pad
);

    always_comb begin
        pad_oe   = func_oe;
        pad_pull = func_pull;
        rd_pad   = rd_func;
        wr_pad   = wr_func;
        case (mode)
            MODE_FLOAT: begin
                pad_oe   = '0;
                pad_pull = '0;
                rd_pad   = '{val: rd_func.val, oe: 1'b0};
                wr_pad   = '{val: wr_func.val, oe: 1'b0};
            end
            MODE_XOR: begin
                pad_oe   = '0;
                rd_pad   = '{val: chain_par[0], oe: 1'b1};
                wr_pad   = '{val: chain_par[1], oe: 1'b1};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xortest_ctrl.sv
module xortest_ctrl
    import xtc_pkg::*;
#(
    parameter int               NPINS  = 48,
    parameter logic [NPINS-1:0] MASK_A = 48'h0000_001F_FFFF,
    parameter logic [NPINS-1:0] MASK_B = 48'h7FFF_FFE0_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_test,
    input  logic             strap_exec,
    input  logic             strap_tck,
    input  logic             strap_tdi,
    input  logic             bus_alive,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] func_oe,
    input  logic [NPINS-1:0] func_pull,
    input  logic             rd_func_val,
    input  logic             rd_func_oe,
    input  logic             wr_func_val,
    input  logic             wr_func_oe,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pull,
    output logic             rd_pad_val,
    output logic             rd_pad_oe,
    output logic             wr_pad_val,
    output logic             wr_pad_oe
);

    localparam logic [NUM_CHAINS-1:0][NPINS-1:0] CHAIN_MASKS = {MASK_B, MASK_A};

    tmode_e                mode;
    strap_t                straps;
    logic [NUM_CHAINS-1:0] chain_par;
    drv_t                  rd_pad, wr_pad;

    assign straps = '{test_en: strap_test, exec: strap_exec,
                      tck: strap_tck, tdi: strap_tdi};

    xtc_strap_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .straps (straps),
        .alive  (bus_alive),
        .mode   (mode)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        xtc_xor_chain #(.NPINS(NPINS), .MASK(CHAIN_MASKS[c])) u_chain (
            .pins   (pin_in),
            .parity (chain_par[c])
        );
    end

    xtc_pad_gate #(.NPINS(NPINS)) u_gate (
        .mode      (mode),
        .func_oe   (func_oe),
        .func_pull (func_pull),
        .rd_func   ('{val: rd_func_val, oe: rd_func_oe}),
        .wr_func   ('{val: wr_func_val, oe: wr_func_oe}),
        .chain_par (chain_par),
        .pad_oe    (pad_oe),
        .pad_pull  (pad_pull),
        .rd_pad    (rd_pad),
        .wr_pad    (wr_pad)
    );

    assign rd_pad_val = rd_pad.val;
    assign rd_pad_oe  = rd_pad.oe;
    assign wr_pad_val = wr_pad.val;
    assign wr_pad_oe  = wr_pad.oe;

    // R2: float mode silences every driver and pull
    assert_float_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FLOAT) |-> (pad_oe == '0 && pad_pull == '0 &&
                                  !rd_pad_oe && !wr_pad_oe));

    // R3: parity-tree mode drives only the two strobe pins
    assert_xor_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_XOR) |-> (pad_oe == '0 && rd_pad_oe && wr_pad_oe));

    // R7: one member of chain A flipping flips the read strobe
    assert_flip_a_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && mode == MODE_XOR && $past(mode) == MODE_XOR &&
         $countones((pin_in ^ $past(pin_in)) & MASK_A) == 1)
        |-> (rd_pad_val != $past(rd_pad_val)));

    // R7: one member of chain B flipping flips the write strobe
    assert_flip_b_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && mode == MODE_XOR && $past(mode) == MODE_XOR &&
         $countones((pin_in ^ $past(pin_in)) & MASK_B) == 1)
        |-> (wr_pad_val != $past(wr_pad_val)));

endmodule

// File: tb/xortest_ctrl_bench.sv
`timescale 1ns/1ps
module xortest_ctrl_bench;

    localparam int NP = 48;
    localparam logic [NP-1:0] MA = 48'h0000_001F_FFFF;
    localparam logic [NP-1:0] MB = 48'h7FFF_FFE0_0000;

    logic clk = 0;
    always #2.5 clk = ~clk;

    logic rst = 1;
    logic s_test = 0, s_exec = 0, s_tck = 0, s_tdi = 0, alive = 1;
    logic [NP-1:0] pins = '0, foe = '0, fpull = '0;
    logic rdv = 0, rdo = 0, wrv = 0, wro = 0;
    logic [NP-1:0] poe, ppull;
    logic rpv, rpo, wpv, wpo;

    xortest_ctrl u_xortest_ctrl (
        .clk(clk), .rst(rst), .strap_test(s_test), .strap_exec(s_exec),
        .strap_tck(s_tck), .strap_tdi(s_tdi), .bus_alive(alive),
        .pin_in(pins), .func_oe(foe), .func_pull(fpull),
        .rd_func_val(rdv), .rd_func_oe(rdo), .wr_func_val(wrv), .wr_func_oe(wro),
        .pad_oe(poe), .pad_pull(ppull), .rd_pad_val(rpv), .rd_pad_oe(rpo),
        .wr_pad_val(wpv), .wr_pad_oe(wpo)
    );

    typedef struct {
        logic [NP-1:0] oe;
        logic [NP-1:0] pull;
        logic [3:0]    strobes;
        string         tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int checks = 0, errors = 0;
    int mdl = 0; // 0 functional, 1 float, 2 parity tree
    bit done = 0;

    function automatic int model_decode(logic t, logic e, logic k, logic d, logic a);
        if (t && !k && d) return e ? (a ? 2 : 0) : 1;
        return 0;
    endfunction

    // monitor: pops and compares away from the clock edge
    initial forever begin
        @(chk_ev);
        #1;
        while (q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = q.pop_front();
            act = {rpv, rpo, wpv, wpo};
            checks++;
            if (poe !== e.oe || ppull !== e.pull || act !== e.strobes) begin
                errors++;
                $display("FAIL %s: oe=%h pull=%h str=%b expected oe=%h pull=%h str=%b",
                         e.tag, poe, ppull, act, e.oe, e.pull, e.strobes);
            end
        end
    end

    task automatic push_expect(string tag);
        exp_t e;
        e.tag = tag;
        case (mdl)
            1: begin e.oe = '0; e.pull = '0; e.strobes = {rdv, 1'b0, wrv, 1'b0}; end
            2: begin e.oe = '0; e.pull = fpull;
                     e.strobes = {^(pins & MA), 1'b1, ^(pins & MB), 1'b1}; end
            default: begin e.oe = foe; e.pull = fpull; e.strobes = {rdv, rdo, wrv, wro}; end
        endcase
        q.push_back(e);
        -> chk_ev;
    endtask

    // drive one vector at a falling edge, check it, then advance the mode model
    task automatic step(logic [NP-1:0] p, logic [NP-1:0] o, logic [NP-1:0] pl,
                        logic [3:0] fs, logic a, string tag);
        @(negedge clk);
        pins = p; foe = o; fpull = pl; {rdv, rdo, wrv, wro} = fs; alive = a;
        push_expect(tag);
        @(posedge clk);
        if (mdl == 2 && !a) mdl = 0;
    endtask

    task automatic do_reset(logic t, logic e, logic k, logic d, logic a);
        @(negedge clk);
        rst = 1; s_test = t; s_exec = e; s_tck = k; s_tdi = d; alive = a;
        @(posedge clk);
        mdl = model_decode(t, e, k, d, a);
        @(negedge clk);
        rst = 0;
        alive = 1;
    endtask

    localparam logic [NP-1:0] PA = 48'hA5C3_1234_9F0E;
    localparam logic [NP-1:0] PB = 48'h5A3C_EDCB_60F1;

    initial begin
        // reset state with plain straps
        @(posedge clk);
        @(negedge clk);
        foe = PA; fpull = PB; {rdv, rdo, wrv, wro} = 4'b1101;
        push_expect("R1 reset state");
        @(posedge clk);
        do_reset(0, 0, 0, 0, 1);
        step(PA, PB, PA, 4'b0110, 1, "R1 functional a");
        step(PB, PA, PB, 4'b1011, 1, "R1 functional b");

        // float mode
        do_reset(1, 0, 0, 1, 1);
        step(PA, '1, '1, 4'b1111, 1, "R2 float all set");
        step(PB, PA, PB, 4'b0101, 1, "R2 float b");
        // straps moved after reset
        @(negedge clk); s_test = 0; s_tdi = 0;
        step(PA, PB, PA, 4'b1111, 1, "R9 straps ignored");

        // parity tree
        do_reset(1, 1, 0, 1, 1);
        step(PA, '1, PB, 4'b0101, 1, "R3 xor enables");
        step('0, PA, PA, 4'b1111, 1, "R5 R6 zero pins");
        step(PA, PB, PA, 4'b0000, 1, "R5 R6 pattern a");
        step(PB, PB, PA, 4'b0000, 1, "R5 R6 pattern b");
        step('1, '0, '0, 4'b0000, 1, "R5 R6 all ones");
        step(PB ^ (48'd1 << 3), '0, '0, 4'b0000, 1, "R7 toggle chain A pin");
        step(PB ^ (48'd1 << 3) ^ (48'd1 << 30), '0, '0, 4'b0000, 1, "R7 toggle chain B pin");
        step(PB ^ (48'd1 << 3) ^ (48'd1 << 30) ^ (48'd1 << 47), '0, '0, 4'b0000, 1,
             "R7 toggle unchained pin");
        @(negedge clk); s_exec = 0;
        step(PA, '1, '1, 4'b1010, 1, "R9 exec strap moved");
        // bus-alive drops: still parity in this cycle, functional after
        step(PA, PB, PA, 4'b1010, 0, "R8 drop same cycle");
        step(PB, PA, PB, 4'b1010, 1, "R8 functional after drop");
        step(PA, PB, PA, 4'b0101, 1, "R8 no re-entry");

        // parity-tree straps without bus power
        do_reset(1, 1, 0, 1, 0);
        step(PA, PB, PA, 4'b1100, 1, "R4 no bus power");

        // near-miss strap patterns
        do_reset(1, 1, 1, 1, 1);
        step(PA, PB, PA, 4'b0011, 1, "R10 tck high");
        do_reset(0, 1, 0, 1, 1);
        step(PB, PA, PB, 4'b1001, 1, "R10 test low");
        do_reset(1, 0, 1, 1, 1);
        step(PA, PA, PB, 4'b0110, 1, "R10 tck high float pattern");

        @(negedge clk);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule